// File: doc/BRIEF.md
# Per-Thread Loop Replay Buffer

This block sits after instruction decode and watches the decoded micro-op stream of each hardware thread. When a taken branch that jumps backwards is decoded, the block begins recording the following micro-ops of that thread. If the same branch (identified by its tag) appears again before the recording exceeds the buffer size, the recorded sequence is a complete loop body. The block then replays that body from its own storage without end, and it asserts a stall to the branch predictor so that fetch and prediction can rest.

Each thread has its own private storage and controller, so one thread can record or replay while the other does something else entirely. Branches are still resolved downstream during replay. A wrong resolution on a thread ends replay for that thread at once: its recording is thrown away, the predictor stall drops, and ordinary fetch takes over from the redirect. Replayed micro-ops leave through a per-thread valid/ready handshake.

Top module: `loop_stream_buf`

## Requirements
- R1: After reset, every thread shows `out_valid` low and `pred_stall` low.
- R2: For a thread with no recording, an accepted micro-op with `in_bwd_taken` high starts a recording under its `in_tag`; that marker micro-op is not stored. Each later micro-op of the thread is stored in order, and when one with `in_bwd_taken` high and the same tag is stored, replay starts: `out_valid` rises in the next cycle.
- R3: If a recording already holds DEPTH micro-ops (64 by default), the next micro-op of that thread, even a closing branch, aborts the recording and no replay follows.
- R4: `pred_stall` of a thread is high in exactly those cycles in which the thread is replaying, including the cycle in which a mispredict arrives.
- R5: While replaying, `out_uop` shows the stored micro-ops in recording order starting at the first; it advances only in a cycle with `out_valid` and `out_ready` both high, and after the last stored entry (the closing branch) it returns to the first.
- R6: A `mispredict` bit for a replaying thread forces its `out_valid` low in the same cycle; from the next cycle `pred_stall` is low and the recording is discarded, so a later closing branch only starts a new recording.
- R7: A `mispredict` bit for a recording thread discards the recording; the thread returns to having no recording.
- R8: Input, mispredict and ready activity of one thread never changes the outputs of another thread.
- R9: Micro-ops presented for a thread that is replaying are ignored and do not alter the replayed sequence.
- R10: A micro-op with `in_bwd_taken` high and a tag different from the one being recorded restarts the recording under the new tag, dropping the entries stored so far.
- R11: A loop body of exactly DEPTH micro-ops, closing branch included, is replayed in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A decoded micro-op is present this cycle |
| in_tid | input | TID_W | Thread that owns the decoded micro-op |
| in_uop | input | UOP_W | Decoded micro-op payload |
| in_bwd_taken | input | 1 | Micro-op is a taken backward branch |
| in_tag | input | TAG_W | Identity of that branch (its address bits) |
| mispredict | input | NT | Per-thread wrong branch resolution |
| out_ready | input | NT | Per-thread consumer accepts a replayed micro-op |
| out_valid | output | NT | Per-thread replayed micro-op is present |
| out_uop | output | NT*UOP_W | Replayed micro-ops, thread t in bits [t*UOP_W +: UOP_W] |
| pred_stall | output | NT | Per-thread request that the branch predictor stop predicting |

## Verification
The hardest state to reach from the ports is the boundary of the storage: a loop of exactly DEPTH entries must replay, while a recording that has already filled every entry must die on the very next micro-op even when that micro-op is the matching closing branch. The bench drives a 64-entry body and a 65-entry body back to back on one thread, with the other thread replaying a short loop at the same time under an irregular ready pattern, and compares both threads against a behavioural model every cycle. Mispredicts are injected both mid-recording and mid-replay, followed by a lone closing branch to show that nothing stale is replayed.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

    // Default geometry of the buffer
    localparam int LSB_THREADS = 2;
    localparam int LSB_DEPTH   = 64;
    localparam int LSB_UOP_W   = 16;
    localparam int LSB_TAG_W   = 12;

    // Per-thread controller state
    typedef enum logic [1:0] {
        LS_IDLE    = 2'd0,
        LS_CAPTURE = 2'd1,
        LS_STREAM  = 2'd2
    } lsb_state_e;

    // Replay pointer step with wrap after the last recorded entry
    function automatic int lsb_next_ptr(input int ptr, input int len);
        return (ptr >= len - 1) ? 0 : ptr + 1;
    endfunction

    // Thread id width that never collapses to zero
    function automatic int lsb_id_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lsb_store.sv
module lsb_store #(
    parameter int DEPTH = lsb_pkg::LSB_DEPTH,
    parameter int UOP_W = lsb_pkg::LSB_UOP_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [UOP_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [UOP_W-1:0] rd_data
);

    logic [UOP_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_addr] <= wr_data;
        end
    end

    assign rd_data = slots[rd_addr];

endmodule

// File: rtl/lsb_ctrl.sv
module lsb_ctrl
    import lsb_pkg::*;
#(
    parameter int DEPTH = LSB_DEPTH,
    parameter int TAG_W = LSB_TAG_W,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             uop_hit,
    input  logic             uop_bwd,
    input  logic [TAG_W-1:0] uop_tag,
    input  logic             flush,
    input  logic             take,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [AW-1:0]    rd_addr,
    output logic             replay_valid,
    output logic             stall
);

    lsb_state_e       st;
    logic [CW-1:0]    fill;
    logic [CW-1:0]    body_len;
    logic [AW-1:0]    rd_ptr;
    logic [TAG_W-1:0] loop_tag;

    logic new_loop;
    logic full;
    logic fire;

    assign new_loop     = uop_hit && uop_bwd && (uop_tag != loop_tag);
    assign full         = (fill == CW'(DEPTH));
    assign replay_valid = (st == LS_STREAM) && !flush;
    assign fire         = replay_valid && take;
    assign stall        = (st == LS_STREAM);
    assign wr_en        = (st == LS_CAPTURE) && uop_hit && !new_loop && !full && !flush;
    assign wr_addr      = fill[AW-1:0];
    assign rd_addr      = rd_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= LS_IDLE;
            fill     <= '0;
            body_len <= '0;
            rd_ptr   <= '0;
            loop_tag <= '0;
        end else if (flush) begin
            st       <= LS_IDLE;
            fill     <= '0;
            body_len <= '0;
            rd_ptr   <= '0;
        end else begin
            unique case (st)
                LS_IDLE: begin
                    if (uop_hit && uop_bwd) begin
                        st       <= LS_CAPTURE;
                        loop_tag <= uop_tag;
                        fill     <= '0;
                    end
                end
                LS_CAPTURE: begin
                    if (new_loop) begin
                        loop_tag <= uop_tag;
                        fill     <= '0;
                    end else if (uop_hit) begin
                        if (full) begin
                            st   <= LS_IDLE;
                            fill <= '0;
                        end else begin
                            fill <= fill + CW'(1);
                            if (uop_bwd) begin
                                st       <= LS_STREAM;
                                body_len <= fill + CW'(1);
                                rd_ptr   <= '0;
                            end
                        end
                    end
                end
                LS_STREAM: begin
                    if (fire) begin
                        rd_ptr <= AW'(lsb_next_ptr(int'(rd_ptr), int'(body_len)));
                    end
                end
                default: st <= LS_IDLE;
            endcase
        end
    end

    // R6
    mp_exit_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (st == LS_IDLE) && !stall);

    // R6
    mp_gate_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> !replay_valid);

    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && (rd_ptr == AW'(body_len - CW'(1)))) |=> (rd_ptr == '0));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == LS_STREAM) && !take && !flush) |=> $stable(rd_ptr));

    // R11
    len_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (st == LS_STREAM) |-> (body_len != '0) && (body_len <= CW'(DEPTH)));

    // R9
    len_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == LS_STREAM) && !flush) |=> $stable(body_len) && (st == LS_STREAM));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

endmodule

// File: rtl/lsb_lane.sv
module lsb_lane
    import lsb_pkg::*;
#(
    parameter int DEPTH = LSB_DEPTH,
    parameter int UOP_W = LSB_UOP_W,
    parameter int TAG_W = LSB_TAG_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             uop_hit,
    input  logic [UOP_W-1:0] uop_data,
    input  logic             uop_bwd,
    input  logic [TAG_W-1:0] uop_tag,
    input  logic             flush,
    input  logic             take,
    output logic             replay_valid,
    output logic [UOP_W-1:0] replay_uop,
    output logic             stall
);

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;

    lsb_ctrl #(
        .DEPTH (DEPTH),
        .TAG_W (TAG_W)
    ) i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .uop_hit      (uop_hit),
        .uop_bwd      (uop_bwd),
        .uop_tag      (uop_tag),
        .flush        (flush),
        .take         (take),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .rd_addr      (rd_addr),
        .replay_valid (replay_valid),
        .stall        (stall)
    );

    lsb_store #(
        .DEPTH (DEPTH),
        .UOP_W (UOP_W)
    ) i_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (uop_data),
        .rd_addr (rd_addr),
        .rd_data (replay_uop)
    );

endmodule

// File: rtl/loop_stream_buf.sv
module loop_stream_buf
    import lsb_pkg::*;
#(
    parameter int NT    = LSB_THREADS,
    parameter int DEPTH = LSB_DEPTH,
    parameter int UOP_W = LSB_UOP_W,
    parameter int TAG_W = LSB_TAG_W,
    localparam int TID_W = lsb_id_width(NT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [TID_W-1:0]    in_tid,
    input  logic [UOP_W-1:0]    in_uop,
    input  logic                in_bwd_taken,
    input  logic [TAG_W-1:0]    in_tag,
    input  logic [NT-1:0]       mispredict,
    input  logic [NT-1:0]       out_ready,
    output logic [NT-1:0]       out_valid,
    output logic [NT*UOP_W-1:0] out_uop,
    output logic [NT-1:0]       pred_stall
);

    for (genvar t = 0; t < NT; t++) begin : g_thread
        logic hit;
        assign hit = in_valid && (in_tid == TID_W'(t));

        lsb_lane #(
            .DEPTH (DEPTH),
            .UOP_W (UOP_W),
            .TAG_W (TAG_W)
        ) i_lane (
            .clk          (clk),
            .rst          (rst),
            .uop_hit      (hit),
            .uop_data     (in_uop),
            .uop_bwd      (in_bwd_taken),
            .uop_tag      (in_tag),
            .flush        (mispredict[t]),
            .take         (out_ready[t]),
            .replay_valid (out_valid[t]),
            .replay_uop   (out_uop[t*UOP_W +: UOP_W]),
            .stall        (pred_stall[t])
        );
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (out_valid == '0) && (pred_stall == '0));

    // R4
    stall_cover_chk: assert property (@(posedge clk) disable iff (rst)
        ((out_valid & ~pred_stall) == '0));

endmodule

// File: tb/test_loop_stream_buf.sv
`timescale 1ns/1ps
module test_loop_stream_buf;

    localparam int NT    = 2;
    localparam int DEPTH = 64;
    localparam int UOP_W = 16;
    localparam int TAG_W = 12;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic [0:0]          in_tid = '0;
    logic [UOP_W-1:0]    in_uop = '0;
    logic                in_bwd_taken = 1'b0;
    logic [TAG_W-1:0]    in_tag = '0;
    logic [NT-1:0]       mispredict = '0;
    logic [NT-1:0]       out_ready = '1;
    logic [NT-1:0]       out_valid;
    logic [NT*UOP_W-1:0] out_uop;
    logic [NT-1:0]       pred_stall;

    always #2.5 clk = ~clk;

    loop_stream_buf #(
        .NT(NT), .DEPTH(DEPTH), .UOP_W(UOP_W), .TAG_W(TAG_W)
    ) i_loop_stream_buf (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_tid(in_tid),
        .in_uop(in_uop), .in_bwd_taken(in_bwd_taken), .in_tag(in_tag),
        .mispredict(mispredict), .out_ready(out_ready), .out_valid(out_valid),
        .out_uop(out_uop), .pred_stall(pred_stall)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    int uop_seq = 1;

    // Behavioural reference: 0 none, 1 recording, 2 replaying
    int m_st   [NT];
    int m_cnt  [NT];
    int m_len  [NT];
    int m_rd   [NT];
    int m_tag  [NT];
    int m_body [NT][DEPTH];

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        for (int t = 0; t < NT; t++) begin
            bit ev;
            ev = (m_st[t] == 2) && !mispredict[t];
            chk(out_valid[t] == ev, "R2 valid", int'(out_valid[t]), int'(ev));
            chk(pred_stall[t] == (m_st[t] == 2), "R4 stall", int'(pred_stall[t]), int'(m_st[t] == 2));
            if (ev && out_valid[t]) begin
                chk(int'(out_uop[t*UOP_W +: UOP_W]) == m_body[t][m_rd[t]], "R5 uop",
                    int'(out_uop[t*UOP_W +: UOP_W]), m_body[t][m_rd[t]]);
            end
        end
    endtask

    task automatic model_update();
        for (int t = 0; t < NT; t++) begin
            bit hit;
            hit = in_valid && (int'(in_tid) == t);
            if (mispredict[t]) begin
                m_st[t] = 0; m_cnt[t] = 0; m_rd[t] = 0;
            end else if (m_st[t] == 0) begin
                if (hit && in_bwd_taken) begin
                    m_st[t] = 1; m_cnt[t] = 0; m_tag[t] = int'(in_tag);
                end
            end else if (m_st[t] == 1) begin
                if (hit && in_bwd_taken && int'(in_tag) != m_tag[t]) begin
                    m_cnt[t] = 0; m_tag[t] = int'(in_tag);
                end else if (hit) begin
                    if (m_cnt[t] == DEPTH) begin
                        m_st[t] = 0; m_cnt[t] = 0;
                    end else begin
                        m_body[t][m_cnt[t]] = int'(in_uop);
                        m_cnt[t]++;
                        if (in_bwd_taken) begin
                            m_st[t] = 2; m_len[t] = m_cnt[t]; m_rd[t] = 0;
                        end
                    end
                end
            end else begin
                if (out_ready[t]) m_rd[t] = (m_rd[t] == m_len[t] - 1) ? 0 : m_rd[t] + 1;
            end
        end
    endtask

    // One cycle: drive at the falling edge, check, then step the model at the rising edge
    task automatic step(input bit v, input int tid, input bit bwd, input int tag);
        in_valid     = v;
        in_tid       = 1'(tid);
        in_uop       = UOP_W'(uop_seq);
        in_bwd_taken = bwd;
        in_tag       = TAG_W'(tag);
        if (v) uop_seq++;
        #1;
        compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
        mispredict = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 0);
    endtask

    task automatic body(input int tid, input int n);
        for (int i = 0; i < n; i++) step(1'b1, tid, 1'b0, 0);
    endtask

    initial begin
        for (int t = 0; t < NT; t++) begin
            m_st[t] = 0; m_cnt[t] = 0; m_len[t] = 0; m_rd[t] = 0; m_tag[t] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        chk(out_valid == '0, "R1 valid after reset", int'(out_valid), 0);
        chk(pred_stall == '0, "R1 stall after reset", int'(pred_stall), 0);
        rst = 1'b0;
        idle(2);

        // R2: short loop on thread 0, replay with a stuttering consumer (R5)
        cur_req = "R2";
        step(1'b1, 0, 1'b1, 'h10);
        body(0, 4);
        step(1'b1, 0, 1'b1, 'h10);
        cur_req = "R5";
        for (int i = 0; i < 14; i++) begin
            out_ready[0] = (i % 3) != 1;
            step(1'b0, 0, 1'b0, 0);
        end
        out_ready = '1;

        // R9: micro-ops for a replaying thread are ignored
        cur_req = "R9";
        body(0, 3);
        step(1'b1, 0, 1'b1, 'h10);
        idle(4);

        // R6: mispredict during replay, then a lone closing branch
        cur_req = "R6";
        mispredict[0] = 1'b1;
        step(1'b0, 0, 1'b0, 0);
        idle(2);
        step(1'b1, 0, 1'b1, 'h10);
        idle(3);
        cur_req = "R6";
        mispredict[0] = 1'b1;
        step(1'b0, 0, 1'b0, 0);

        // R7: mispredict while recording on thread 1
        cur_req = "R7";
        step(1'b1, 1, 1'b1, 'h22);
        body(1, 3);
        mispredict[1] = 1'b1;
        step(1'b0, 0, 1'b0, 0);
        step(1'b1, 1, 1'b1, 'h22);
        body(1, 2);
        step(1'b1, 1, 1'b1, 'h22);
        idle(8);
        mispredict[1] = 1'b1;
        step(1'b0, 0, 1'b0, 0);

        // R10: a different backward branch restarts the recording
        cur_req = "R10";
        step(1'b1, 0, 1'b1, 'h30);
        body(0, 2);
        step(1'b1, 0, 1'b1, 'h31);
        body(0, 3);
        step(1'b1, 0, 1'b1, 'h31);
        idle(6);

        // R3: thread 1 fills all entries, closing branch arrives one too late
        cur_req = "R3";
        step(1'b1, 1, 1'b1, 'h40);
        body(1, DEPTH);
        step(1'b1, 1, 1'b1, 'h40);
        idle(4);

        // R11: exactly DEPTH entries; R8: thread 0 keeps replaying meanwhile
        cur_req = "R11";
        step(1'b1, 1, 1'b1, 'h40);
        body(1, DEPTH - 1);
        step(1'b1, 1, 1'b1, 'h40);
        cur_req = "R8";
        for (int i = 0; i < 140; i++) begin
            out_ready[0] = (i % 4) != 0;
            out_ready[1] = (i % 5) != 2;
            step(1'b0, 0, 1'b0, 0);
        end
        out_ready = '1;
        mispredict[0] = 1'b1;
        step(1'b0, 0, 1'b0, 0);
        idle(6);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule